// File: doc/BRIEF.md
# USB IN Endpoint Response Controller

This block decides, for a single device-side USB IN endpoint, what answer goes back on the bus each time an IN token arrives. It watches a token strobe, a bit that marks the endpoint as isochronous, and the state of the endpoint's transmit FIFO: how many words it holds now and how many words the next queued packet needs. Register-style pulses arm the endpoint with a packet count, force it into NAK mode, and release it from that mode. For every token the block registers one of four replies: a data packet, a zero-length packet, a NAK handshake, or silence. Serialization, CRC, the PHY and the FIFO storage are handled elsewhere.

Two small state machines hold the control state. The NAK machine has the states NK_OFF, NK_ARMING and NK_ON. A set pulse moves NK_OFF to NK_ARMING. With no pulse, NK_ARMING moves on to NK_ON. A set pulse in NK_ARMING also moves it to NK_ON. A clear pulse without a set pulse returns NK_ARMING or NK_ON to NK_OFF. NAK mode is in force in NK_ARMING and NK_ON. The NAK-effective flag is shown in NK_ON only. The endpoint machine has the states EP_IDLE and EP_ARMED. In EP_IDLE, an enable pulse with a non-zero count loads the count and moves to EP_ARMED. EP_ARMED goes back to EP_IDLE when the last counted packet leaves, and at that point the block gives a transfer-complete pulse.

An isochronous endpoint is armed for one micro-frame's packets. Because a new enable is refused until the previous transfer has completed, data for the next periodic transaction cannot be queued early.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset, reply_o is 0 (none), and ep_armed_o, nak_mode_o, nak_eff_o and xfer_done_o are all low.
- R2: When the endpoint is armed and not in NAK mode, a token with pkt_words_i non-zero and fifo_words_i >= pkt_words_i gives reply_o = 1 (data) in the cycle after the token. This reply uses up one packet from the count. A packet is never started while the FIFO holds less than the whole packet.
- R3: When the endpoint is armed and not in NAK mode, a token with pkt_words_i = 0 gives reply_o = 2 (zero-length) whatever the FIFO level is. This reply uses up one packet from the count.
- R4: When the endpoint is armed and not in NAK mode but the FIFO holds less than the whole packet, a token gives reply_o = 3 (NAK) for a non-isochronous endpoint and reply_o = 2 (zero-length) for an isochronous one. No packet is used up from the count.
- R5: When the endpoint is not armed and not in NAK mode, a token gives reply_o = 3 (NAK) for a non-isochronous endpoint and reply_o = 0 (none) for an isochronous one.
- R6: In NAK mode, a token gives reply_o = 3 for a non-isochronous endpoint and reply_o = 2 for an isochronous one, even when the FIFO holds a full packet. No packet is used up from the count.
- R7: A set_nak_i pulse turns nak_mode_o on after that edge. nak_eff_o rises one cycle later and stays high until NAK mode is cleared.
- R8: A clear_nak_i pulse without set_nak_i drops nak_mode_o and nak_eff_o after that edge. When both pulses arrive in the same cycle, set_nak_i wins.
- R9: An ep_enable_i pulse with a non-zero pkt_count_i arms the endpoint after that edge. The pulse is ignored while the endpoint is already armed, and it is ignored when pkt_count_i is 0.
- R10: The reply that uses up the last counted packet comes with a one-cycle xfer_done_o pulse, and ep_armed_o goes low in that same cycle.
- R11: In a cycle with no token, reply_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| token_i | input | 1 | IN token received strobe |
| iso_i | input | 1 | Endpoint is isochronous |
| fifo_words_i | input | FIFO_W | Words currently held in the transmit FIFO |
| pkt_words_i | input | FIFO_W | Size in words of the next packet (0 = zero-length) |
| ep_enable_i | input | 1 | Arm pulse for the endpoint |
| pkt_count_i | input | CNT_W | Number of packets to send, loaded with the arm pulse |
| set_nak_i | input | 1 | Enter forced-NAK mode |
| clear_nak_i | input | 1 | Leave forced-NAK mode |
| reply_o | output | 2 | Reply: 0 none, 1 data, 2 zero-length, 3 NAK |
| ep_armed_o | output | 1 | Endpoint is armed |
| nak_mode_o | output | 1 | Forced-NAK mode is in force |
| nak_eff_o | output | 1 | Sticky NAK-effective interrupt flag |
| xfer_done_o | output | 1 | Transfer-complete pulse |

## Verification
Tokens are driven with FIFO levels above, equal to and below the packet size, and with zero-length packets, for both endpoint types. This separates the full-packet, shortage and zero-length branches, and the type-dependent answers. The same tokens are repeated while the endpoint is disarmed and while it is in NAK mode. This shows that NAK mode overrides a full FIFO, and that a disarmed endpoint answers differently from one in NAK mode. Set and clear pulses, including both in the same cycle, are mixed with arm pulses that come while the endpoint is already armed or that carry a zero count. These check the flag timing, the priority of set over clear, and the refusal to re-arm before transfer-complete.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

    typedef enum logic [1:0] {
        RPL_NONE = 2'd0,
        RPL_DATA = 2'd1,
        RPL_ZLP  = 2'd2,
        RPL_NAK  = 2'd3
    } reply_e;

    typedef enum logic [1:0] {
        NK_OFF    = 2'd0,
        NK_ARMING = 2'd1,
        NK_ON     = 2'd2
    } nak_state_e;

    typedef enum logic {
        EP_IDLE  = 1'b0,
        EP_ARMED = 1'b1
    } ep_state_e;

endpackage

// File: rtl/usb_in_nak_fsm.sv
module usb_in_nak_fsm
    import usb_in_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_nak,
    input  logic clear_nak,
    output logic nak_mode,
    output logic nak_eff
);

    nak_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NK_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NK_OFF:    if (set_nak) state_d = NK_ARMING;
            NK_ARMING: if (set_nak || !clear_nak) state_d = NK_ON;
                       else state_d = NK_OFF;
            NK_ON:     if (!set_nak && clear_nak) state_d = NK_OFF;
            default:   state_d = NK_OFF;
        endcase
    end

    always_comb begin
        nak_mode = (state_q != NK_OFF);
        nak_eff  = (state_q == NK_ON);
    end

    a_r7_set_enters: assert property (@(posedge clk) disable iff (!rst_n)
        set_nak |=> nak_mode);
    a_r8_clear_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_nak && !set_nak) |=> (!nak_mode && !nak_eff));
    a_r7_eff_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nak_eff) |-> $past(nak_mode));

endmodule

// File: rtl/usb_in_ep_arm.sv
module usb_in_ep_arm
    import usb_in_ep_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] count_load,
    input  logic             consume,
    output logic             armed,
    output logic             done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ep_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EP_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (state_q)
            EP_IDLE: begin
                if (enable && (count_load != '0)) begin
                    state_d = EP_ARMED;
                    cnt_d   = count_load;
                end
            end
            EP_ARMED: begin
                if (consume) begin
                    if (cnt_q == ONE) begin
                        state_d = EP_IDLE;
                        done_d  = 1'b1;
                    end
                    cnt_d = cnt_q - ONE;
                end
            end
            default: state_d = EP_IDLE;
        endcase
    end

    always_comb begin
        armed = (state_q == EP_ARMED);
        done  = done_q;
    end

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !armed);
    a_r9_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> ($past(enable) && ($past(count_load) != '0)));

endmodule

// File: rtl/usb_in_reply_sel.sv
module usb_in_reply_sel
    import usb_in_ep_pkg::*;
#(
    parameter int FIFO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              token,
    input  logic              iso,
    input  logic [FIFO_W-1:0] fifo_words,
    input  logic [FIFO_W-1:0] pkt_words,
    input  logic              armed,
    input  logic              nak_mode,
    output reply_e            reply,
    output logic              consume
);

    reply_e reply_d, reply_q;
    logic   short_fifo;

    always_comb begin
        short_fifo = (fifo_words < pkt_words);
        reply_d    = RPL_NONE;
        consume    = 1'b0;
        if (!token) begin
            reply_d = RPL_NONE;
        end else if (nak_mode) begin
            reply_d = iso ? RPL_ZLP : RPL_NAK;
        end else if (!armed) begin
            reply_d = iso ? RPL_NONE : RPL_NAK;
        end else if (pkt_words == '0) begin
            reply_d = RPL_ZLP;
            consume = 1'b1;
        end else if (!short_fifo) begin
            reply_d = RPL_DATA;
            consume = 1'b1;
        end else begin
            reply_d = iso ? RPL_ZLP : RPL_NAK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) reply_q <= RPL_NONE;
        else        reply_q <= reply_d;
    end

    assign reply = reply_q;

    a_r6_nak_blocks_data: assert property (@(posedge clk) disable iff (!rst_n)
        (token && nak_mode) |=> (reply != RPL_DATA));
    a_r2_whole_packet: assert property (@(posedge clk) disable iff (!rst_n)
        (token && (pkt_words != '0) && (fifo_words < pkt_words)) |=> (reply != RPL_DATA));
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !token |=> (reply == RPL_NONE));

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
    import usb_in_ep_pkg::*;
#(
    parameter int FIFO_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              token_i,
    input  logic              iso_i,
    input  logic [FIFO_W-1:0] fifo_words_i,
    input  logic [FIFO_W-1:0] pkt_words_i,
    input  logic              ep_enable_i,
    input  logic [CNT_W-1:0]  pkt_count_i,
    input  logic              set_nak_i,
    input  logic              clear_nak_i,
    output logic [1:0]        reply_o,
    output logic              ep_armed_o,
    output logic              nak_mode_o,
    output logic              nak_eff_o,
    output logic              xfer_done_o
);

    logic   nak_mode, armed, consume;
    reply_e reply;

    usb_in_nak_fsm u_nak (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_nak   (set_nak_i),
        .clear_nak (clear_nak_i),
        .nak_mode  (nak_mode),
        .nak_eff   (nak_eff_o)
    );

    usb_in_ep_arm #(.CNT_W(CNT_W)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ep_enable_i),
        .count_load (pkt_count_i),
        .consume    (consume),
        .armed      (armed),
        .done       (xfer_done_o)
    );

    usb_in_reply_sel #(.FIFO_W(FIFO_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .token      (token_i),
        .iso        (iso_i),
        .fifo_words (fifo_words_i),
        .pkt_words  (pkt_words_i),
        .armed      (armed),
        .nak_mode   (nak_mode),
        .reply      (reply),
        .consume    (consume)
    );

    assign reply_o    = reply;
    assign ep_armed_o = armed;
    assign nak_mode_o = nak_mode;

endmodule

// File: tb/sim_usb_in_ep_ctrl.sv
module sim_usb_in_ep_ctrl;

    localparam int FW = 8;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          token_i = 1'b0, iso_i = 1'b0;
    logic [FW-1:0] fifo_words_i = '0, pkt_words_i = '0;
    logic          ep_enable_i = 1'b0;
    logic [CW-1:0] pkt_count_i = '0;
    logic          set_nak_i = 1'b0, clear_nak_i = 1'b0;
    logic [1:0]    reply_o;
    logic          ep_armed_o, nak_mode_o, nak_eff_o, xfer_done_o;

    int errors = 0;
    int checks = 0;

    bit         m_mode = 0, m_eff = 0, m_armed = 0;
    int         m_cnt = 0;
    logic [1:0] e_reply = 0;
    bit         e_done = 0;
    string      e_tag = "R11";

    always #4 clk = ~clk;

    usb_in_ep_ctrl #(.FIFO_W(FW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .token_i(token_i), .iso_i(iso_i),
        .fifo_words_i(fifo_words_i), .pkt_words_i(pkt_words_i),
        .ep_enable_i(ep_enable_i), .pkt_count_i(pkt_count_i),
        .set_nak_i(set_nak_i), .clear_nak_i(clear_nak_i),
        .reply_o(reply_o), .ep_armed_o(ep_armed_o), .nak_mode_o(nak_mode_o),
        .nak_eff_o(nak_eff_o), .xfer_done_o(xfer_done_o)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected reply from the requirement rules; returns 1 when a packet is used.
    function automatic bit model_reply(bit tok, bit iso, int fifo, int pkt,
                                       output logic [1:0] r, output string tag);
        model_reply = 0;
        if (!tok) begin r = 0; tag = "R11"; end
        else if (m_mode) begin r = iso ? 2 : 3; tag = "R6"; end
        else if (!m_armed) begin r = iso ? 0 : 3; tag = "R5"; end
        else if (pkt == 0) begin r = 2; tag = "R3"; model_reply = 1; end
        else if (fifo >= pkt) begin r = 1; tag = "R2"; model_reply = 1; end
        else begin r = iso ? 2 : 3; tag = "R4"; end
    endfunction

    task automatic step(bit tok, bit iso, int fifo, int pkt, bit en, int cnt,
                        bit setn, bit clrn);
        bit used;
        bit nm, ne;
        @(negedge clk);
        token_i = tok; iso_i = iso; fifo_words_i = FW'(fifo); pkt_words_i = FW'(pkt);
        ep_enable_i = en; pkt_count_i = CW'(cnt); set_nak_i = setn; clear_nak_i = clrn;
        used = model_reply(tok, iso, fifo, pkt, e_reply, e_tag);
        e_done = 0;
        if (m_armed && used) begin
            m_cnt--;
            if (m_cnt == 0) begin m_armed = 0; e_done = 1; end
        end else if (!m_armed && en && cnt != 0) begin
            m_armed = 1; m_cnt = cnt;
        end
        if (setn) begin nm = 1; ne = m_mode; end
        else if (clrn) begin nm = 0; ne = 0; end
        else begin nm = m_mode; ne = m_mode; end
        m_mode = nm; m_eff = ne;
        @(posedge clk);
        #1;
        check(e_tag, "reply_o", int'(reply_o), int'(e_reply));
        check("R10", "xfer_done_o", int'(xfer_done_o), int'(e_done));
        check("R9", "ep_armed_o", int'(ep_armed_o), int'(m_armed));
        check("R8", "nak_mode_o", int'(nak_mode_o), int'(m_mode));
        check("R7", "nak_eff_o", int'(nak_eff_o), int'(m_eff));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_1234);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "reply_o", int'(reply_o), 0);
        check("R1", "ep_armed_o", int'(ep_armed_o), 0);
        check("R1", "nak_flags", int'({nak_mode_o, nak_eff_o}), 0);
        check("R1", "xfer_done_o", int'(xfer_done_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R5 disarmed endpoint, both types
        step(1, 0, 20, 4, 0, 0, 0, 0);
        step(1, 1, 20, 4, 0, 0, 0, 0);
        // R9 zero count ignored, then arm with two packets
        step(0, 0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 1, 2, 0, 0);
        // R9 re-arm while armed ignored
        step(0, 0, 0, 0, 1, 9, 0, 0);
        // R4 shortage both types, R2 exact fit
        step(1, 0, 3, 4, 0, 0, 0, 0);
        step(1, 1, 3, 4, 0, 0, 0, 0);
        step(1, 0, 4, 4, 0, 0, 0, 0);
        // R3 zero-length with empty FIFO is the last packet: R10 pulse
        step(1, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);
        // R6 NAK mode overrides full FIFO; R7 flag one cycle later
        step(0, 0, 0, 0, 1, 3, 1, 0);
        step(1, 0, 50, 4, 0, 0, 0, 0);
        step(1, 1, 50, 4, 0, 0, 0, 0);
        // R8 both pulses same cycle: set wins
        step(0, 0, 0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 1);
        step(1, 0, 50, 4, 0, 0, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            bit t, s, c, e, io;
            int f, p, n;
            t  = ($urandom_range(0, 1) == 1);
            io = ($urandom_range(0, 3) == 0);
            s  = ($urandom_range(0, 29) == 0);
            c  = ($urandom_range(0, 24) == 0);
            e  = ($urandom_range(0, 14) == 0);
            f  = $urandom_range(0, 15);
            p  = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 12);
            n  = $urandom_range(0, 3);
            step(t, io, f, p, e, n, s, c);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule